// File: doc/BRIEF.md
# Two-Level Control Decoder for a Single-Cycle Core

This block turns the operation fields of a 32-bit instruction into the control lines of a single-cycle datapath. It receives the 6-bit major opcode and the 6-bit function field. It drives eight datapath steering and write-enable lines, and a 3-bit operation select for the ALU. The block is purely combinational, so its outputs follow its inputs within the same cycle. It has no clock and no reset.

Decoding happens in two stages. The opcode stage produces the datapath lines and a 3-bit intermediate ALU class. That class marks register-register instructions separately from the fixed classes Or, Add and Subtract. The ALU stage combines the class with the low four function bits to form the final ALU select. For the fixed classes it ignores the function field completely.

Instructions covered: the register-register group (add, subtract, and, or, set-on-less-than), or-immediate, load word, store word, branch-if-equal and jump. Any output whose value does not matter for an instruction is driven low. An opcode outside this set changes no state.

Top module: `cpu_ctl_decode`

## Requirements
- R1: Opcode 000000 (register-register) drives dest_is_rd_o=1, opnd_b_imm_o=0, wb_from_mem_o=0, rf_we_o=1, dmem_we_o=0, br_eq_o=0, jump_o=0 and imm_sext_o=0.
- R2: Opcode 001101 (or-immediate) drives opnd_b_imm_o=1, rf_we_o=1 and imm_sext_o=0, with all other control lines 0. It also drives alu_sel_o=001 (Or).
- R3: Opcode 100011 (load) drives opnd_b_imm_o=1, wb_from_mem_o=1, rf_we_o=1 and imm_sext_o=1, with all other lines 0. It also drives alu_sel_o=010 (Add).
- R4: Opcode 101011 (store) drives opnd_b_imm_o=1, dmem_we_o=1 and imm_sext_o=1, with all other lines 0. It also drives alu_sel_o=010 (Add).
- R5: Opcode 000100 (branch-if-equal) drives br_eq_o=1 with all other lines 0. It also drives alu_sel_o=110 (Subtract).
- R6: Opcode 000010 (jump) drives jump_o=1 with all other lines 0. It also drives alu_sel_o=010.
- R7: Any other opcode drives every control line to 0 and alu_sel_o=010.
- R8: For opcode 000000, funct_i[3:0] selects the ALU operation. The mapping is 0000→010 (add), 0010→110 (subtract), 0100→000 (and), 0101→001 (or) and 1010→111 (set-on-less-than).
- R9: For opcode 000000, funct_i[5:4] has no effect on any output.
- R10: For opcode 000000 with any other value of funct_i[3:0], alu_sel_o is 010 and rf_we_o stays 1.
- R11: For every opcode other than 000000, funct_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Major opcode field of the instruction |
| funct_i | input | 6 | Function field of the instruction |
| dest_is_rd_o | output | 1 | Write destination is the third register field (else the second) |
| opnd_b_imm_o | output | 1 | ALU second operand comes from the extended immediate |
| wb_from_mem_o | output | 1 | Register write data comes from data memory |
| rf_we_o | output | 1 | Register file write enable |
| dmem_we_o | output | 1 | Data memory write enable |
| br_eq_o | output | 1 | Conditional branch on equal |
| jump_o | output | 1 | Unconditional jump |
| imm_sext_o | output | 1 | Immediate is sign-extended (else zero-extended) |
| alu_sel_o | output | 3 | ALU operation select |

## Verification
Each of the six supported opcodes is applied and the full output word is compared. This separates instructions that share most controls, for example load against store, or or-immediate against load. The register-register form is swept over its five function codes, and then over the same low nibbles with different high bits, to show that only funct_i[3:0] matters. Unlisted nibbles are also applied and must fall back to Add. Fixed-class opcodes are paired with deliberately misleading function fields to show that the function field has no effect. All 58 unlisted opcodes are then swept and must leave every write, branch and jump line low.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    parameter int OPC_W = 6;
    parameter int FN_W  = 6;
    parameter int SEL_W = 3;
    parameter int CLS_W = 3;
    localparam int FN_LO_W = 4;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

    // intermediate ALU class produced by the opcode stage
    typedef enum logic [CLS_W-1:0] {
        CLS_ADD = 3'b000,
        CLS_SUB = 3'b001,
        CLS_OR  = 3'b010,
        CLS_FN  = 3'b100
    } alu_cls_e;

    // final ALU select
    typedef enum logic [SEL_W-1:0] {
        SEL_AND = 3'b000,
        SEL_OR  = 3'b001,
        SEL_ADD = 3'b010,
        SEL_SUB = 3'b110,
        SEL_SLT = 3'b111
    } alu_sel_e;

    typedef struct packed {
        logic     dest_is_rd;
        logic     opnd_b_imm;
        logic     wb_from_mem;
        logic     rf_we;
        logic     dmem_we;
        logic     br_eq;
        logic     jump;
        logic     imm_sext;
        alu_cls_e cls;
    } dp_ctl_t;

    localparam dp_ctl_t CTL_IDLE = '{
        dest_is_rd: 1'b0, opnd_b_imm: 1'b0, wb_from_mem: 1'b0, rf_we: 1'b0,
        dmem_we: 1'b0, br_eq: 1'b0, jump: 1'b0, imm_sext: 1'b0, cls: CLS_ADD
    };

    function automatic alu_sel_e fn_to_sel(input logic [FN_LO_W-1:0] fn);
        alu_sel_e s;
        case (fn)
            4'b0000: s = SEL_ADD;
            4'b0010: s = SEL_SUB;
            4'b0100: s = SEL_AND;
            4'b0101: s = SEL_OR;
            4'b1010: s = SEL_SLT;
            default: s = SEL_ADD;
        endcase
        return s;
    endfunction

    function automatic alu_sel_e cls_to_sel(input alu_cls_e c);
        alu_sel_e s;
        if (c[0])      s = SEL_SUB;
        else if (c[1]) s = SEL_OR;
        else           s = SEL_ADD;
        return s;
    endfunction

endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
    import ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output dp_ctl_t          ctl_o
);
    always_comb begin
        ctl_o = CTL_IDLE;
        case (opcode_i)
            OPC_REG: begin
                ctl_o.dest_is_rd = 1'b1;
                ctl_o.rf_we      = 1'b1;
                ctl_o.cls        = CLS_FN;
            end
            OPC_ORI: begin
                ctl_o.opnd_b_imm = 1'b1;
                ctl_o.rf_we      = 1'b1;
                ctl_o.cls        = CLS_OR;
            end
            OPC_LOAD: begin
                ctl_o.opnd_b_imm  = 1'b1;
                ctl_o.wb_from_mem = 1'b1;
                ctl_o.rf_we       = 1'b1;
                ctl_o.imm_sext    = 1'b1;
                ctl_o.cls         = CLS_ADD;
            end
            OPC_STORE: begin
                ctl_o.opnd_b_imm = 1'b1;
                ctl_o.dmem_we    = 1'b1;
                ctl_o.imm_sext   = 1'b1;
                ctl_o.cls        = CLS_ADD;
            end
            OPC_BEQ: begin
                ctl_o.br_eq = 1'b1;
                ctl_o.cls   = CLS_SUB;
            end
            OPC_JUMP: begin
                ctl_o.jump = 1'b1;
            end
            default: ctl_o = CTL_IDLE;
        endcase
    end
endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
    import ctl_pkg::*;
(
    input  alu_cls_e           cls_i,
    input  logic [FN_LO_W-1:0] fn_lo_i,
    output alu_sel_e           sel_o
);
    always_comb begin
        if (cls_i[CLS_W-1]) sel_o = fn_to_sel(fn_lo_i);
        else                sel_o = cls_to_sel(cls_i);
    end
endmodule

// File: rtl/cpu_ctl_decode.sv
module cpu_ctl_decode
    import ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [FN_W-1:0]  funct_i,
    output logic             dest_is_rd_o,
    output logic             opnd_b_imm_o,
    output logic             wb_from_mem_o,
    output logic             rf_we_o,
    output logic             dmem_we_o,
    output logic             br_eq_o,
    output logic             jump_o,
    output logic             imm_sext_o,
    output logic [SEL_W-1:0] alu_sel_o
);
    dp_ctl_t  ctl;
    alu_sel_e sel;
    logic     unused_fn_hi;

    assign unused_fn_hi = ^funct_i[FN_W-1:FN_LO_W];

    ctl_main_dec i_main (
        .opcode_i (opcode_i),
        .ctl_o    (ctl)
    );

    ctl_alu_dec i_alu (
        .cls_i   (ctl.cls),
        .fn_lo_i (funct_i[FN_LO_W-1:0]),
        .sel_o   (sel)
    );

    assign dest_is_rd_o  = ctl.dest_is_rd;
    assign opnd_b_imm_o  = ctl.opnd_b_imm;
    assign wb_from_mem_o = ctl.wb_from_mem;
    assign rf_we_o       = ctl.rf_we;
    assign dmem_we_o     = ctl.dmem_we;
    assign br_eq_o       = ctl.br_eq;
    assign jump_o        = ctl.jump;
    assign imm_sext_o    = ctl.imm_sext;
    assign alu_sel_o     = sel;
endmodule

// File: rtl/cpu_ctl_decode_chk.sv
module cpu_ctl_decode_chk
    import ctl_pkg::*;
(
    input logic [OPC_W-1:0] opcode_i,
    input logic [FN_W-1:0]  funct_i,
    input logic             dest_is_rd_o,
    input logic             opnd_b_imm_o,
    input logic             wb_from_mem_o,
    input logic             rf_we_o,
    input logic             dmem_we_o,
    input logic             br_eq_o,
    input logic             jump_o,
    input logic             imm_sext_o,
    input logic [SEL_W-1:0] alu_sel_o
);
    logic known;
    logic listed;

    assign known  = !$isunknown({opcode_i, funct_i});
    assign listed = (opcode_i == OPC_REG)   || (opcode_i == OPC_ORI)  ||
                    (opcode_i == OPC_LOAD)  || (opcode_i == OPC_STORE) ||
                    (opcode_i == OPC_BEQ)   || (opcode_i == OPC_JUMP);

    always_comb begin
        if (known) begin
            // R1
            rtype_ctl_chk: assert (!(opcode_i == OPC_REG) ||
                (dest_is_rd_o && rf_we_o && !dmem_we_o && !br_eq_o && !jump_o && !wb_from_mem_o))
                else $error("register-register controls wrong");
            // R4
            store_ctl_chk: assert (!(opcode_i == OPC_STORE) ||
                (dmem_we_o && !rf_we_o && imm_sext_o && alu_sel_o == 3'b010))
                else $error("store controls wrong");
            // R6
            jump_excl_chk: assert (!jump_o || (!rf_we_o && !dmem_we_o && !br_eq_o))
                else $error("jump raised with a write or branch");
            // R7
            unlisted_quiet_chk: assert (listed ||
                (!rf_we_o && !dmem_we_o && !br_eq_o && !jump_o && alu_sel_o == 3'b010))
                else $error("unlisted opcode changes state");
            // R8
            slt_sel_chk: assert (!(opcode_i == OPC_REG && funct_i[3:0] == 4'b1010) ||
                alu_sel_o == 3'b111)
                else $error("set-on-less-than select wrong");
            // R5
            beq_sub_chk: assert (!(opcode_i == OPC_BEQ) || (br_eq_o && alu_sel_o == 3'b110))
                else $error("branch select wrong");
        end
    end
endmodule

bind cpu_ctl_decode cpu_ctl_decode_chk i_chk (.*);

// File: tb/test_cpu_ctl_decode.sv
module test_cpu_ctl_decode;
    logic       clk = 1'b0;
    logic [5:0] opcode;
    logic [5:0] funct;
    logic       dest_is_rd, opnd_b_imm, wb_from_mem, rf_we, dmem_we, br_eq, jump, imm_sext;
    logic [2:0] alu_sel;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 0;

    always #10 clk = ~clk;

    cpu_ctl_decode i_cpu_ctl_decode (
        .opcode_i      (opcode),
        .funct_i       (funct),
        .dest_is_rd_o  (dest_is_rd),
        .opnd_b_imm_o  (opnd_b_imm),
        .wb_from_mem_o (wb_from_mem),
        .rf_we_o       (rf_we),
        .dmem_we_o     (dmem_we),
        .br_eq_o       (br_eq),
        .jump_o        (jump),
        .imm_sext_o    (imm_sext),
        .alu_sel_o     (alu_sel)
    );

    // expected word: {dest_is_rd, opnd_b_imm, wb_from_mem, rf_we, dmem_we, br_eq, jump, imm_sext, alu_sel}
    task automatic apply_chk(input logic [5:0] op, input logic [5:0] fn,
                             input logic [10:0] exp, input string req);
        logic [10:0] got;
        @(posedge clk);
        opcode = op;
        funct  = fn;
        @(negedge clk);
        got = {dest_is_rd, opnd_b_imm, wb_from_mem, rf_we, dmem_we, br_eq, jump, imm_sext, alu_sel};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b fn=%b actual=%b expected=%b", req, op, fn, got, exp);
        end
    endtask

    task automatic t_initial;
        apply_chk(6'b000000, 6'b100000, 11'b1_0_0_1_0_0_0_0_010, "R1 idle start");
    endtask

    task automatic t_rtype;
        apply_chk(6'b000000, 6'b100000, 11'b1_0_0_1_0_0_0_0_010, "R1 R8 add");
        apply_chk(6'b000000, 6'b100010, 11'b1_0_0_1_0_0_0_0_110, "R8 sub");
        apply_chk(6'b000000, 6'b100100, 11'b1_0_0_1_0_0_0_0_000, "R8 and");
        apply_chk(6'b000000, 6'b100101, 11'b1_0_0_1_0_0_0_0_001, "R8 or");
        apply_chk(6'b000000, 6'b101010, 11'b1_0_0_1_0_0_0_0_111, "R8 slt");
    endtask

    task automatic t_fn_high;
        apply_chk(6'b000000, 6'b001010, 11'b1_0_0_1_0_0_0_0_111, "R9 slt hi=00");
        apply_chk(6'b000000, 6'b111010, 11'b1_0_0_1_0_0_0_0_111, "R9 slt hi=11");
        apply_chk(6'b000000, 6'b010100, 11'b1_0_0_1_0_0_0_0_000, "R9 and hi=01");
        apply_chk(6'b000000, 6'b000010, 11'b1_0_0_1_0_0_0_0_110, "R9 sub hi=00");
    endtask

    task automatic t_fn_unlisted;
        apply_chk(6'b000000, 6'b100111, 11'b1_0_0_1_0_0_0_0_010, "R10 fn 0111");
        apply_chk(6'b000000, 6'b101111, 11'b1_0_0_1_0_0_0_0_010, "R10 fn 1111");
        apply_chk(6'b000000, 6'b100011, 11'b1_0_0_1_0_0_0_0_010, "R10 fn 0011");
    endtask

    task automatic t_fixed;
        apply_chk(6'b001101, 6'b000000, 11'b0_1_0_1_0_0_0_0_001, "R2 ori");
        apply_chk(6'b100011, 6'b000000, 11'b0_1_1_1_0_0_0_1_010, "R3 load");
        apply_chk(6'b101011, 6'b000000, 11'b0_1_0_0_1_0_0_1_010, "R4 store");
        apply_chk(6'b000100, 6'b000000, 11'b0_0_0_0_0_1_0_0_110, "R5 beq");
        apply_chk(6'b000010, 6'b000000, 11'b0_0_0_0_0_0_1_0_010, "R6 jump");
    endtask

    task automatic t_fn_ignored;
        apply_chk(6'b001101, 6'b100010, 11'b0_1_0_1_0_0_0_0_001, "R11 ori with sub fn");
        apply_chk(6'b000100, 6'b100101, 11'b0_0_0_0_0_1_0_0_110, "R11 beq with or fn");
        apply_chk(6'b100011, 6'b101010, 11'b0_1_1_1_0_0_0_1_010, "R11 load with slt fn");
        apply_chk(6'b101011, 6'b100100, 11'b0_1_0_0_1_0_0_1_010, "R11 store with and fn");
        apply_chk(6'b000010, 6'b100010, 11'b0_0_0_0_0_0_1_0_010, "R11 jump with sub fn");
    endtask

    task automatic t_unlisted_ops;
        for (int k = 0; k < 64; k++) begin
            logic [5:0] op;
            op = 6'(k);
            if (op != 6'b000000 && op != 6'b001101 && op != 6'b100011 &&
                op != 6'b101011 && op != 6'b000100 && op != 6'b000010)
                apply_chk(op, 6'b101010, 11'b0_0_0_0_0_0_0_0_010, "R7 unlisted opcode");
        end
    endtask

    initial begin
        opcode = 6'b000000;
        funct  = 6'b100000;
        t_initial();
        t_rtype();
        t_fn_high();
        t_fn_unlisted();
        t_fixed();
        t_fn_ignored();
        t_unlisted_ops();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule